// File: doc/BRIEF.md
# Serial Receiver with Break Recognition

This block takes an asynchronous serial line, resynchronises it, and samples every bit sixteen times per bit period, as paced by a one-cycle oversampling enable from an external rate generator. Each frame is a low start bit, eight or nine data bits sent least significant first, and a high stop bit. When parity is on, the last data bit is the parity bit. Finished words leave on a valid/ready stream with framing and parity error bits attached. Overrun, noise and break are sticky flags. A status pin shows when a frame is being received.

The block also counts consecutive zero bit decisions to spot a break, meaning the line held low for a whole frame or longer. An enable input chooses what a break does. With the enable low, the break is treated as an ordinary frame: an all-zero word is delivered with its framing error set, and normal parity and overrun rules apply. With the enable high, the break only raises a dedicated sticky flag. No word is delivered, and the held word and its error bits stay as they were. In this mode a zero run that starts partway through a byte also counts as a break. After any break the receiver waits for the line to go high before it looks for a new start bit.

Stream rules: `rx_valid` rises when a word is ready and stays high, with `rx_data`, `rx_fe` and `rx_pe` held steady, until a cycle in which `rx_ready` is high. A consumer that holds `rx_ready` low does not stall the line. A frame that finishes while the stream is still stalled is dropped and `ovr_flag` is set.

Top module: `uart_brk_rx`

## Requirements
- R1: Each bit is decided by a majority vote of oversamples 7, 8 and 9 of 16, counted from the first oversample that sees the start bit low. A start bit whose vote is 1 is rejected as a false start, and no word results.
- R2: With `nine_bit`=0 a frame carries 8 data bits and `rx_data[8]` is 0. With `nine_bit`=1 it carries 9 data bits. In both cases the data bits arrive least significant first.
- R3: When `parity_en`=1, the last data bit is parity. `rx_pe` is 1 when the XOR of all data bits differs from `parity_odd` (0 selects even parity, 1 selects odd).
- R4: While `rx_valid`=1 and `rx_ready`=0, `rx_valid`, `rx_data`, `rx_fe` and `rx_pe` hold their values.
- R5: A frame that completes while `rx_valid`=1 and `rx_ready`=0 is discarded, `ovr_flag` is set, and the held word is kept.
- R6: A stop bit decided as 0 yields a word with `rx_fe`=1 whenever it does not turn out to be a break.
- R7: `noise_flag` is set when the three votes of any bit disagree. The bit value still follows the majority.
- R8: A break is a run of 10 consecutive zero decisions (`nine_bit`=0) or 11 (`nine_bit`=1). Any 1 decision restarts the count, so a run one bit shorter than this is not a break.
- R9: With `brk_det_en`=0, a break delivers the word 0 with `rx_fe`=1 and parity checked as usual, and `brk_flag` stays 0. The receiver then waits for the line to go high before it accepts a new start bit.
- R10: With `brk_det_en`=1, a break sets `brk_flag`, delivers no word, and leaves `rx_valid`, `rx_data`, `rx_fe`, `rx_pe` and `ovr_flag` unchanged.
- R11: With `brk_det_en`=1, a zero run that begins partway through a byte and reaches the threshold is recognised as a break, and no word is delivered.
- R12: `brk_flag`, `ovr_flag` and `noise_flag` stay set until a one-cycle `sticky_clr` pulse. If a new event arrives in the same cycle as the clear, the flag is set.
- R13: `rx_active` is 1 from start-bit detection until the frame ends. It is 0 at reset, when idle, and while the receiver waits for the line to go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, sixteen per bit |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| nine_bit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| parity_en | input | 1 | Last data bit is parity |
| parity_odd | input | 1 | 0 even, 1 odd parity |
| brk_det_en | input | 1 | Break raises only brk_flag |
| sticky_clr | input | 1 | One-cycle clear of sticky flags |
| rx_valid | output | 1 | Word available |
| rx_ready | input | 1 | Consumer accepts word |
| rx_data | output | 9 | Received data bits |
| rx_fe | output | 1 | Framing error of this word |
| rx_pe | output | 1 | Parity error of this word |
| ovr_flag | output | 1 | Sticky overrun |
| noise_flag | output | 1 | Sticky noise |
| brk_flag | output | 1 | Sticky break detected |
| rx_active | output | 1 | Frame reception in progress |

## Verification
The bench sends zero runs exactly one bit short of the break threshold and exactly at it, in both frame lengths. A receiver that counts the threshold off by one either misses breaks or turns valid all-zero words into breaks. It also sends a run that starts mid-byte and a break that arrives while a word is stalled: a detector that judges the zero run only at the stop bit would deliver a framing-error word there, and one that touches the output stage would damage the held word. A one-sample glitch on the middle vote checks that the bit still follows the majority and that noise is flagged. Back-to-back frames under back-pressure check that the newer word, not the older one, is the one dropped.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_ZRUN  = 2'd2,
    ST_WHIGH = 2'd3
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_os_sampler.sv
module uart_os_sampler
  import uart_brk_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic align,
  input  logic run,
  output logic strobe,
  output logic bit_val,
  output logic bit_noisy
);
  localparam int CW    = $clog2(OVS + 1);
  localparam int S_MID = OVS / 2;
  localparam int S_LO  = S_MID - 1;
  localparam int S_HI  = S_MID + 1;

  logic [CW-1:0] cnt, cnt_nx;
  logic          s_lo, s_mid;

  always_comb cnt_nx = (cnt == CW'(OVS)) ? CW'(1) : cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      s_lo      <= 1'b1;
      s_mid     <= 1'b1;
      strobe    <= 1'b0;
      bit_val   <= 1'b1;
      bit_noisy <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (align && tick) begin
        cnt <= CW'(1);
      end else if (run && tick) begin
        cnt <= cnt_nx;
        if (cnt_nx == CW'(S_LO))  s_lo  <= line;
        if (cnt_nx == CW'(S_MID)) s_mid <= line;
        if (cnt_nx == CW'(S_HI)) begin
          strobe    <= 1'b1;
          bit_val   <= vote3(s_lo, s_mid, line);
          bit_noisy <= !((s_lo == s_mid) && (s_mid == line));
        end
      end
    end
  end
endmodule

// File: rtl/uart_zero_run.sv
module uart_zero_run #(
  parameter int MAXF = 11,
  localparam int ZW  = $clog2(MAXF + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          bit_val,
  input  logic          clr,
  input  logic [ZW-1:0] thr,
  output logic          hit
);
  logic [ZW-1:0] run_cnt;

  assign hit = strobe && !bit_val && ((run_cnt + ZW'(1)) >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (clr)            run_cnt <= '0;
    else if (strobe) begin
      if (bit_val)                    run_cnt <= '0;
      else if (run_cnt != ZW'(MAXF + 1)) run_cnt <= run_cnt + ZW'(1);
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DW_MIN   = 8,
  parameter int DW_MAX   = 9,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_line,
  input  logic              nine_bit,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              brk_det_en,
  input  logic              sticky_clr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DW_MAX-1:0] rx_data,
  output logic              rx_fe,
  output logic              rx_pe,
  output logic              ovr_flag,
  output logic              noise_flag,
  output logic              brk_flag,
  output logic              rx_active
);
  localparam int FR_MIN = DW_MIN + 2;
  localparam int FR_MAX = DW_MAX + 2;
  localparam int IW     = $clog2(DW_MAX + 2);
  localparam int ZW     = $clog2(FR_MAX + 2);

  logic              line_s;
  logic              strobe, bitv, noisy, zhit, zclr, align, run;
  rx_state_e         st, st_nx;
  logic [IW-1:0]     idx, idx_nx, dw;
  logic [DW_MAX-1:0] shreg, sh_nx;
  logic              dlv, dlv_fe, brk_set, frame_pe;
  logic [ZW-1:0]     thr;

  uart_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  assign run = (st == ST_RECV) || (st == ST_ZRUN);

  uart_os_sampler #(.OVS(OVS)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .align(align), .run(run),
    .strobe(strobe), .bit_val(bitv), .bit_noisy(noisy)
  );

  assign thr = nine_bit ? ZW'(FR_MAX) : ZW'(FR_MIN);

  uart_zero_run #(.MAXF(FR_MAX)) u_zrun (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .bit_val(bitv),
    .clr(zclr), .thr(thr), .hit(zhit)
  );

  assign dw        = nine_bit ? IW'(DW_MAX) : IW'(DW_MIN);
  assign frame_pe  = parity_en && ((^shreg) != parity_odd);
  assign rx_active = run;

  always_comb begin
    st_nx   = st;
    idx_nx  = idx;
    sh_nx   = shreg;
    dlv     = 1'b0;
    dlv_fe  = 1'b0;
    brk_set = 1'b0;
    zclr    = 1'b0;
    align   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (tick16 && !line_s) begin
          align  = 1'b1;
          st_nx  = ST_RECV;
          idx_nx = '0;
          sh_nx  = '0;
        end
      end
      ST_RECV: begin
        if (strobe) begin
          if (idx == '0) begin
            if (bitv) st_nx = ST_IDLE;
            else      idx_nx = IW'(1);
          end else if (idx <= dw) begin
            sh_nx[idx - IW'(1)] = bitv;
            idx_nx = idx + IW'(1);
          end else if (bitv) begin
            dlv   = 1'b1;
            st_nx = ST_IDLE;
          end else if (!brk_det_en) begin
            dlv    = 1'b1;
            dlv_fe = 1'b1;
            st_nx  = ST_WHIGH;
          end else if (zhit) begin
            brk_set = 1'b1;
            st_nx   = ST_WHIGH;
          end else begin
            st_nx = ST_ZRUN;
          end
        end
      end
      ST_ZRUN: begin
        if (strobe) begin
          if (bitv) begin
            dlv    = 1'b1;
            dlv_fe = 1'b1;
            st_nx  = ST_IDLE;
          end else if (zhit) begin
            brk_set = 1'b1;
            st_nx   = ST_WHIGH;
          end
        end
      end
      default: begin
        if (tick16 && line_s) begin
          st_nx = ST_IDLE;
          zclr  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      shreg <= '0;
    end else begin
      st    <= st_nx;
      idx   <= idx_nx;
      shreg <= sh_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_fe      <= 1'b0;
      rx_pe      <= 1'b0;
      ovr_flag   <= 1'b0;
      noise_flag <= 1'b0;
      brk_flag   <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (sticky_clr) begin
        ovr_flag   <= 1'b0;
        noise_flag <= 1'b0;
        brk_flag   <= 1'b0;
      end
      if (dlv) begin
        if (rx_valid && !rx_ready) begin
          ovr_flag <= 1'b1;
        end else begin
          rx_valid <= 1'b1;
          rx_data  <= shreg;
          rx_fe    <= dlv_fe;
          rx_pe    <= frame_pe;
        end
      end
      if (strobe && noisy) noise_flag <= 1'b1;
      if (brk_set)         brk_flag   <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk #(
  parameter int DW_MAX = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              brk_det_en,
  input logic              sticky_clr,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DW_MAX-1:0] rx_data,
  input logic              rx_fe,
  input logic              rx_pe,
  input logic              ovr_flag,
  input logic              brk_flag
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_fe) && $stable(rx_pe)));

  p_ovr_keeps_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> (rx_valid && $stable(rx_data)));

  p_brk_only_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(brk_det_en));

  p_brk_no_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> (!$rose(rx_valid) && $stable(ovr_flag)));

  p_brk_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !sticky_clr) |=> brk_flag);

  p_ovr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !sticky_clr) |=> ovr_flag);
endmodule

bind uart_brk_rx uart_brk_rx_chk #(.DW_MAX(DW_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_det_en(brk_det_en), .sticky_clr(sticky_clr),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_fe(rx_fe), .rx_pe(rx_pe), .ovr_flag(ovr_flag), .brk_flag(brk_flag)
);

// File: tb/tb_uart_brk_rx.sv
module tb_uart_brk_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b1;
  logic rx_line = 1'b1;
  logic nine_bit = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic brk_det_en = 1'b0, sticky_clr = 1'b0, rx_ready = 1'b1;
  logic rx_valid, rx_fe, rx_pe, ovr_flag, noise_flag, brk_flag, rx_active;
  logic [8:0] rx_data;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [10:0] q_word[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  uart_brk_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .nine_bit(nine_bit), .parity_en(parity_en), .parity_odd(parity_odd),
    .brk_det_en(brk_det_en), .sticky_clr(sticky_clr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_fe(rx_fe), .rx_pe(rx_pe), .ovr_flag(ovr_flag),
    .noise_flag(noise_flag), .brk_flag(brk_flag), .rx_active(rx_active)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_time(input logic b, input int glitch);
    for (int c = 0; c < 16; c++) begin
      rx_line = (glitch != 0 && c == 7) ? ~b : b;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int nbits);
    for (int i = 0; i < nbits; i++) bit_time(1'b1, 0);
  endtask

  task automatic zeros(input int nbits);
    for (int i = 0; i < nbits; i++) bit_time(1'b0, 0);
  endtask

  function automatic int dwidth();
    return nine_bit ? 9 : 8;
  endfunction

  // sends start, data LSB first, stop; expect=1 queues the predicted word
  task automatic frame(input logic [8:0] d, input logic stop, input int gbit,
                       input bit expect_w, input string tag);
    logic [8:0] dm;
    dm = nine_bit ? d : {1'b0, d[7:0]};
    if (expect_w) begin
      q_word.push_back({!stop, parity_en && ((^dm) != parity_odd), dm});
      q_tag.push_back(tag);
    end
    bit_time(1'b0, 0);
    for (int i = 0; i < dwidth(); i++) bit_time(dm[i], (gbit == i) ? 1 : 0);
    bit_time(stop, 0);
    idle(3);
  endtask

  task automatic pulse_clr();
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (q_word.size() == 0) begin
        check("R2 unexpected word", {5'd0, rx_fe, rx_pe, rx_data}, 16'hFFFF);
      end else begin
        logic [10:0] w;
        string t;
        w = q_word.pop_front();
        t = q_tag.pop_front();
        check(t, {5'd0, rx_fe, rx_pe, rx_data}, {5'd0, w});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R13 reset active", {15'd0, rx_active}, 16'd0);
    check("R4 reset valid", {15'd0, rx_valid}, 16'd0);
    check("R12 reset flags", {13'd0, brk_flag, ovr_flag, noise_flag}, 16'd0);
    rst_n = 1'b1;
    idle(2);

    // R2 plain 8-bit and 9-bit words
    frame(9'h0A5, 1'b1, -1, 1, "R2 8bit A5");
    frame(9'h03C, 1'b1, -1, 1, "R2 8bit 3C");
    nine_bit = 1'b1;
    frame(9'h1A5, 1'b1, -1, 1, "R2 9bit 1A5");
    nine_bit = 1'b0;

    // R3 parity even and odd
    parity_en = 1'b1;
    frame(9'h003, 1'b1, -1, 1, "R3 even ok");
    frame(9'h007, 1'b1, -1, 1, "R3 even bad");
    parity_odd = 1'b1;
    frame(9'h007, 1'b1, -1, 1, "R3 odd ok");
    parity_en = 1'b0; parity_odd = 1'b0;

    // R13 active mid-frame
    fork
      frame(9'h066, 1'b1, -1, 1, "R13 word");
      begin
        repeat (80) @(negedge clk);
        check("R13 active mid", {15'd0, rx_active}, 16'd1);
      end
    join
    check("R13 idle after", {15'd0, rx_active}, 16'd0);

    // R1 false start: 4-cycle low pulse
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    idle(2);
    check("R1 false start", {15'd0, rx_valid}, 16'd0);
    check("R1 false start idle", {15'd0, rx_active}, 16'd0);

    // R7 noise: glitch on middle vote of data bit 2
    frame(9'h055, 1'b1, 2, 1, "R7 majority word");
    check("R7 noise flag", {15'd0, noise_flag}, 16'd1);
    pulse_clr();
    check("R12 noise cleared", {15'd0, noise_flag}, 16'd0);

    // R6 framing error, both modes
    frame(9'h081, 1'b0, -1, 1, "R6 fe legacy");
    brk_det_en = 1'b1;
    frame(9'h081, 1'b0, -1, 1, "R6 fe bd mode");
    brk_det_en = 1'b0;

    // R9 legacy break, with odd parity
    q_word.push_back({1'b1, 1'b0, 9'h000}); q_tag.push_back("R9 legacy break");
    zeros(14); idle(3);
    parity_en = 1'b1; parity_odd = 1'b1;
    q_word.push_back({1'b1, 1'b1, 9'h000}); q_tag.push_back("R9 legacy break parity");
    zeros(14); idle(3);
    parity_en = 1'b0; parity_odd = 1'b0;
    check("R9 no brk flag", {15'd0, brk_flag}, 16'd0);

    // R10 break while a word is held
    brk_det_en = 1'b1;
    rx_ready = 1'b0;
    frame(9'h042, 1'b1, -1, 1, "R10 held word");
    zeros(14); idle(3);
    check("R10 brk flag", {15'd0, brk_flag}, 16'd1);
    check("R10 held valid", {15'd0, rx_valid}, 16'd1);
    check("R10 held data", {7'd0, rx_data}, 16'h042);
    check("R10 no overrun", {15'd0, ovr_flag}, 16'd0);
    rx_ready = 1'b1;
    idle(1);
    check("R12 brk sticky", {15'd0, brk_flag}, 16'd1);
    pulse_clr();
    check("R12 brk cleared", {15'd0, brk_flag}, 16'd0);

    // R11 break starting mid-byte
    bit_time(1'b0, 0); bit_time(1'b1, 0); bit_time(1'b1, 0); bit_time(1'b1, 0);
    zeros(12); idle(3);
    check("R11 midbyte brk", {15'd0, brk_flag}, 16'd1);
    pulse_clr();

    // R8 thresholds: one short is a word, exact is a break
    frame(9'h000, 1'b1, -1, 1, "R8 9 zeros word");
    check("R8 8bit short", {15'd0, brk_flag}, 16'd0);
    zeros(10); idle(3);
    check("R8 8bit exact", {15'd0, brk_flag}, 16'd1);
    pulse_clr();
    nine_bit = 1'b1;
    frame(9'h000, 1'b1, -1, 1, "R8 10 zeros word");
    check("R8 9bit short", {15'd0, brk_flag}, 16'd0);
    zeros(11); idle(3);
    check("R8 9bit exact", {15'd0, brk_flag}, 16'd1);
    pulse_clr();
    nine_bit = 1'b0;
    brk_det_en = 1'b0;

    // R5 overrun under back-pressure
    rx_ready = 1'b0;
    frame(9'h011, 1'b1, -1, 1, "R5 first kept");
    frame(9'h022, 1'b1, -1, 0, "R5 dropped");
    check("R5 overrun", {15'd0, ovr_flag}, 16'd1);
    check("R4 data held", {7'd0, rx_data}, 16'h011);
    rx_ready = 1'b1;
    idle(1);
    pulse_clr();
    check("R12 ovr cleared", {15'd0, ovr_flag}, 16'd0);

    idle(2);
    check("R2 all words seen", q_word.size()[15:0], 16'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule